// File: doc/BRIEF.md
# Circular Descriptor Ring Pointer Tracker

This block keeps the address of the current descriptor in a circular list of DMA descriptors for one transfer direction. Software-visible settings reach it as plain levels: the list base address, the tail address, the ring length and a descriptor gap count. Single-cycle strobes report a base-address write, a tail-address write, a consumed descriptor and the result of an ownership check on a fetched descriptor. The block answers with the current descriptor address, a flag that is set when the current pointer has caught up with the tail, a three-way engine state, and one-cycle event pulses for "buffer unavailable" and "process stopped".

Each descriptor occupies a stride of `skip_len * BUS_BYTES + DESC_BYTES` bytes. A programmed ring length N means N+1 descriptors, so the pointer wraps back to the base after N+1 advances. The engine runs only while both the start command and the direction enable are high. It suspends when it meets a descriptor it does not own, or when it reaches the tail. A later tail write resumes it. No data moves through the block. Every pin is a plain control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `desc_ring_ptr`

## Requirements
- R1: After reset, state is 0 (stopped), the current address is 0, the ring-empty flag is 1 and both event outputs are 0. The state encoding is 0 stopped, 1 running, 2 suspended, and 3 never occurs.
- R2: Each accepted advance moves the current address forward by `skip_len * BUS_BYTES + 16` bytes. With BUS_BYTES=8, a gap count of 1 gives 24 bytes and a gap count of 2 gives 32 bytes.
- R3: With ring length N, the advance taken from the last entry (base + N*stride) returns the current address to the base. This happens after N+1 advances from the base.
- R4: A `base_wr` pulse copies `base_addr` into the current address on the next edge, in any state.
- R5: In the stopped state, with `run_cmd` and `dir_en` both high, the next edge enters running, reloads the current address from `base_addr`, and sets ring-empty to (`base_addr` == `tail_addr`).
- R6: An advance is taken only in the running state. After it, ring-empty equals (new address == `tail_addr`). An advance while stopped or suspended leaves the address unchanged.
- R7: If ring-empty becomes or stays 1 while running, the state moves to suspended on that edge and `evt_unavail` is 1 for exactly one cycle.
- R8: An ownership result with `own_valid`=1 and `own_ok`=0 while running moves the state to suspended and pulses `evt_unavail`. Ownership results in any other state are ignored.
- R9: A tail write with `tail_addr` different from the current address clears ring-empty. A tail write while suspended returns the state to running and keeps the current address.
- R10: If `run_cmd` or `dir_en` is low while running or suspended, the state goes to stopped and `evt_stopped` is 1 for exactly one cycle. The two event outputs are never 1 together.
- R11: When an advance and a tail write arrive in the same cycle, ring-empty compares the advanced address with the newly written tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_en | input | 1 | Direction enable level |
| run_cmd | input | 1 | Start command level (low = stop) |
| base_addr | input | ADDR_W | Ring base address |
| base_wr | input | 1 | Base address written (pulse) |
| tail_addr | input | ADDR_W | Tail address |
| tail_wr | input | 1 | Tail address written (pulse) |
| ring_len | input | LEN_W | Ring length N (N+1 descriptors) |
| skip_len | input | SKIP_W | Gap between descriptors, in bus words |
| advance | input | 1 | Current descriptor consumed (pulse) |
| own_valid | input | 1 | Ownership check result valid (pulse) |
| own_ok | input | 1 | Fetched descriptor is owned by the engine |
| cur_addr | output | ADDR_W | Current descriptor address |
| ring_empty | output | 1 | Current address equals tail |
| state | output | 2 | 0 stopped, 1 running, 2 suspended |
| evt_unavail | output | 1 | Buffer-unavailable event pulse |
| evt_stopped | output | 1 | Process-stopped event pulse |

## Verification
Two functions can land on the same edge: an advance and a tail write. The tail write tries to clear the empty flag, while the advance recomputes the flag from the moved pointer. The bench pulses both strobes together, with a tail value equal to the advanced address. It then expects ring-empty to be 1, the state to be suspended and `evt_unavail` to be 1 on that edge. A comparison against the old address would leave the engine running instead. A second overlap, a tail write equal to the current address while suspended, is judged by one cycle of running followed by a new suspend pulse.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    RS_STOP = 2'd0,
    RS_RUN  = 2'd1,
    RS_SUSP = 2'd2
  } ring_state_e;
endpackage

// File: rtl/ring_stride_calc.sv
module ring_stride_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 10,
  parameter int SKIP_W     = 3,
  parameter int BUS_BYTES  = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic [SKIP_W-1:0] skip_len,
  input  logic [LEN_W-1:0]  ring_len,
  output logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] span
);
  localparam int BUS_SHIFT = $clog2(BUS_BYTES);

  logic [ADDR_W-1:0] gap_bytes;
  logic [ADDR_W-1:0] entries;

  generate
    if ((1 << BUS_SHIFT) == BUS_BYTES) begin : g_pow2
      assign gap_bytes = ADDR_W'(skip_len) << BUS_SHIFT;
    end else begin : g_mul
      assign gap_bytes = ADDR_W'(skip_len) * ADDR_W'(BUS_BYTES);
    end
  endgenerate

  assign stride  = gap_bytes + ADDR_W'(DESC_BYTES);
  assign entries = ADDR_W'(ring_len) + ADDR_W'(1);
  assign span    = entries * stride;
endmodule

// File: rtl/ring_next_addr.sv
module ring_next_addr #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [ADDR_W-1:0] span,
  output logic [ADDR_W-1:0] next
);
  logic [ADDR_W-1:0] offs;

  // The offset stays below 2*span while cur lies in the ring, so one
  // conditional subtraction replaces a full modulo.
  always_comb begin
    offs = cur - base + stride;
    if (offs >= span) next = base + (offs - span);
    else              next = base + offs;
  end
endmodule

// File: rtl/ring_ptr_track.sv
module ring_ptr_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_go,
  input  logic              adv_ok,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              tail_wr,
  input  logic [ADDR_W-1:0] tail_addr,
  input  logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] cur_q,
  output logic              empty_q,
  output logic              empty_d
);
  logic [ADDR_W-1:0] cur_d;

  always_comb begin
    cur_d   = cur_q;
    empty_d = empty_q;
    if (start_go) begin
      cur_d   = base_addr;
      empty_d = (base_addr == tail_addr);
    end else begin
      if (base_wr)     cur_d = base_addr;
      else if (adv_ok) cur_d = next_addr;
      if (adv_ok && !base_wr)                 empty_d = (next_addr == tail_addr);
      else if (tail_wr && tail_addr != cur_q) empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      empty_q <= 1'b1;
    end else begin
      cur_q   <= cur_d;
      empty_q <= empty_d;
    end
  end

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> cur_q == $past(base_addr)); // R5
  AST_BASE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && !start_go) |=> cur_q == $past(base_addr)); // R4
  AST_EMPTY_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ok && !base_wr && !start_go) |=> empty_q == (cur_q == $past(tail_addr))); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_ok && !base_wr && !start_go) |=> $stable(cur_q)); // R6
endmodule

// File: rtl/ring_ctrl_fsm.sv
module ring_ctrl_fsm
  import ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_cmd,
  input  logic        dir_en,
  input  logic        advance,
  input  logic        own_valid,
  input  logic        own_ok,
  input  logic        tail_wr,
  input  logic        empty_d,
  output ring_state_e state_q,
  output logic        start_go,
  output logic        adv_ok,
  output logic        evt_unavail,
  output logic        evt_stopped
);
  ring_state_e state_d;
  logic        go;
  logic        unavail_d;
  logic        stopped_d;

  assign go       = run_cmd && dir_en;
  assign start_go = (state_q == RS_STOP) && go;
  assign adv_ok   = (state_q == RS_RUN) && go && advance;

  always_comb begin
    state_d   = state_q;
    unavail_d = 1'b0;
    stopped_d = 1'b0;
    unique case (state_q)
      RS_STOP: if (go) state_d = RS_RUN;
      RS_RUN: begin
        if (!go) begin
          state_d   = RS_STOP;
          stopped_d = 1'b1;
        end else if ((own_valid && !own_ok) || empty_d) begin
          state_d   = RS_SUSP;
          unavail_d = 1'b1;
        end
      end
      RS_SUSP: begin
        if (!go) begin
          state_d   = RS_STOP;
          stopped_d = 1'b1;
        end else if (tail_wr) begin
          state_d = RS_RUN;
        end
      end
      default: state_d = RS_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RS_STOP;
      evt_unavail <= 1'b0;
      evt_stopped <= 1'b0;
    end else begin
      state_q     <= state_d;
      evt_unavail <= unavail_d;
      evt_stopped <= stopped_d;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'd3); // R1
  AST_UNAVAIL_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_unavail |-> (state_q == RS_SUSP) && ($past(state_q) == RS_RUN)); // R7
  AST_STOP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stopped |-> (state_q == RS_STOP) && ($past(state_q) != RS_STOP)); // R10
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_unavail && evt_stopped)); // R10
  AST_OWN_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_RUN && go && own_valid && !own_ok) |=> state_q == RS_SUSP); // R8
endmodule

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 10,
  parameter int SKIP_W     = 3,
  parameter int BUS_BYTES  = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_en,
  input  logic              run_cmd,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] tail_addr,
  input  logic              tail_wr,
  input  logic [LEN_W-1:0]  ring_len,
  input  logic [SKIP_W-1:0] skip_len,
  input  logic              advance,
  input  logic              own_valid,
  input  logic              own_ok,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              ring_empty,
  output logic [1:0]        state,
  output logic              evt_unavail,
  output logic              evt_stopped
);
  import ring_pkg::*;

  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] next_addr;
  logic              start_go;
  logic              adv_ok;
  logic              empty_d;
  ring_state_e       st;

  ring_stride_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SKIP_W(SKIP_W),
    .BUS_BYTES(BUS_BYTES), .DESC_BYTES(DESC_BYTES)
  ) u_stride (
    .skip_len(skip_len), .ring_len(ring_len), .stride(stride), .span(span)
  );

  ring_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .cur(cur_addr), .base(base_addr), .stride(stride), .span(span), .next(next_addr)
  );

  ring_ptr_track #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .adv_ok(adv_ok),
    .base_wr(base_wr), .base_addr(base_addr), .tail_wr(tail_wr),
    .tail_addr(tail_addr), .next_addr(next_addr), .cur_q(cur_addr),
    .empty_q(ring_empty), .empty_d(empty_d)
  );

  ring_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .dir_en(dir_en),
    .advance(advance), .own_valid(own_valid), .own_ok(own_ok),
    .tail_wr(tail_wr), .empty_d(empty_d), .state_q(st),
    .start_go(start_go), .adv_ok(adv_ok),
    .evt_unavail(evt_unavail), .evt_stopped(evt_stopped)
  );

  assign state = st;

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ok && !base_wr && (cur_addr - base_addr + stride == span)) |=>
      cur_addr == $past(base_addr)); // R3
endmodule

// File: tb/desc_ring_ptr_test.sv
module desc_ring_ptr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_en = 1'b0, run_cmd = 1'b0;
  logic [31:0] base_addr = '0, tail_addr = '0;
  logic        base_wr = 1'b0, tail_wr = 1'b0;
  logic [9:0]  ring_len = '0;
  logic [2:0]  skip_len = '0;
  logic        advance = 1'b0, own_valid = 1'b0, own_ok = 1'b0;
  logic [31:0] cur_addr;
  logic        ring_empty, evt_unavail, evt_stopped;
  logic [1:0]  state;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  desc_ring_ptr uut (
    .clk(clk), .rst_n(rst_n), .dir_en(dir_en), .run_cmd(run_cmd),
    .base_addr(base_addr), .base_wr(base_wr), .tail_addr(tail_addr),
    .tail_wr(tail_wr), .ring_len(ring_len), .skip_len(skip_len),
    .advance(advance), .own_valid(own_valid), .own_ok(own_ok),
    .cur_addr(cur_addr), .ring_empty(ring_empty), .state(state),
    .evt_unavail(evt_unavail), .evt_stopped(evt_stopped)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
    cycles++;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic [31:0] a, logic e, logic [1:0] s, logic u, logic p);
    chk(req, "cur_addr", cur_addr, a);
    chk(req, "ring_empty", 32'(ring_empty), 32'(e));
    chk(req, "state", 32'(state), 32'(s));
    chk(req, "evt_unavail", 32'(evt_unavail), 32'(u));
    chk(req, "evt_stopped", 32'(evt_stopped), 32'(p));
  endtask

  task automatic t_reset();
    chk_all("R1", 32'h0, 1'b1, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_base_and_start();
    skip_len = 3'd1; ring_len = 10'd3; base_addr = 32'h1000; tail_addr = 32'h1030;
    dir_en = 1'b1;
    base_wr = 1'b1; tick(); base_wr = 1'b0;
    chk_all("R4", 32'h1000, 1'b1, 2'd0, 1'b0, 1'b0);
    run_cmd = 1'b1; tick();
    chk_all("R5", 32'h1000, 1'b0, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_advance_to_tail();
    advance = 1'b1; tick(); advance = 1'b0;
    chk_all("R2", 32'h1018, 1'b0, 2'd1, 1'b0, 1'b0);
    advance = 1'b1; tick(); advance = 1'b0;
    chk_all("R7", 32'h1030, 1'b1, 2'd2, 1'b1, 1'b0);
    tick();
    chk_all("R7 pulse", 32'h1030, 1'b1, 2'd2, 1'b0, 1'b0);
  endtask

  task automatic t_resume_and_wrap();
    tail_addr = 32'h1000; tail_wr = 1'b1; tick(); tail_wr = 1'b0;
    chk_all("R9", 32'h1030, 1'b0, 2'd1, 1'b0, 1'b0);
    advance = 1'b1; tick(); advance = 1'b0;
    chk_all("R2", 32'h1048, 1'b0, 2'd1, 1'b0, 1'b0);
    advance = 1'b1; tick(); advance = 1'b0;
    chk_all("R3", 32'h1000, 1'b1, 2'd2, 1'b1, 1'b0);
  endtask

  task automatic t_own_fail();
    tail_addr = 32'h1030; tail_wr = 1'b1; tick(); tail_wr = 1'b0;
    chk_all("R9", 32'h1000, 1'b0, 2'd1, 1'b0, 1'b0);
    own_valid = 1'b1; own_ok = 1'b0; tick(); own_valid = 1'b0;
    chk_all("R8", 32'h1000, 1'b0, 2'd2, 1'b1, 1'b0);
    own_valid = 1'b1; tick(); own_valid = 1'b0;
    chk_all("R8 ignored", 32'h1000, 1'b0, 2'd2, 1'b0, 1'b0);
    advance = 1'b1; tick(); advance = 1'b0;
    chk_all("R6 ignored", 32'h1000, 1'b0, 2'd2, 1'b0, 1'b0);
  endtask

  task automatic t_concurrent();
    tail_wr = 1'b1; tick(); tail_wr = 1'b0;
    chk_all("R9", 32'h1000, 1'b0, 2'd1, 1'b0, 1'b0);
    tail_addr = 32'h1018; tail_wr = 1'b1; advance = 1'b1; tick();
    tail_wr = 1'b0; advance = 1'b0;
    chk_all("R11", 32'h1018, 1'b1, 2'd2, 1'b1, 1'b0);
    tail_wr = 1'b1; tick(); tail_wr = 1'b0;
    chk_all("R9 equal tail", 32'h1018, 1'b1, 2'd1, 1'b0, 1'b0);
    tick();
    chk_all("R7 resuspend", 32'h1018, 1'b1, 2'd2, 1'b1, 1'b0);
  endtask

  task automatic t_stop();
    tail_addr = 32'h1048; tail_wr = 1'b1; tick(); tail_wr = 1'b0;
    chk_all("R9", 32'h1018, 1'b0, 2'd1, 1'b0, 1'b0);
    run_cmd = 1'b0; tick();
    chk_all("R10", 32'h1018, 1'b0, 2'd0, 1'b0, 1'b1);
    tick();
    chk_all("R10 pulse", 32'h1018, 1'b0, 2'd0, 1'b0, 1'b0);
    run_cmd = 1'b1; tick();
    chk_all("R5 restart", 32'h1000, 1'b0, 2'd1, 1'b0, 1'b0);
    dir_en = 1'b0; tick();
    chk_all("R10 disable", 32'h1000, 1'b0, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic t_other_stride();
    run_cmd = 1'b0; dir_en = 1'b1;
    skip_len = 3'd2; ring_len = 10'd1; base_addr = 32'h2000; tail_addr = 32'h3000;
    base_wr = 1'b1; tick(); base_wr = 1'b0;
    chk_all("R4", 32'h2000, 1'b0, 2'd0, 1'b0, 1'b0);
    run_cmd = 1'b1; tick();
    chk_all("R5", 32'h2000, 1'b0, 2'd1, 1'b0, 1'b0);
    advance = 1'b1; tick();
    chk_all("R2 gap2", 32'h2020, 1'b0, 2'd1, 1'b0, 1'b0);
    tick(); advance = 1'b0;
    chk_all("R3 two entries", 32'h2000, 1'b0, 2'd1, 1'b0, 1'b0);
    run_cmd = 1'b0; tick();
    tail_addr = 32'h2000; run_cmd = 1'b1; tick();
    chk_all("R5 empty start", 32'h2000, 1'b1, 2'd1, 1'b0, 1'b0);
    tick();
    chk_all("R7 empty start", 32'h2000, 1'b1, 2'd2, 1'b1, 1'b0);
  endtask

  initial begin
    #1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_base_and_start();
    t_advance_to_tail();
    t_resume_and_wrap();
    t_own_fail();
    t_concurrent();
    t_stop();
    t_other_stride();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule